// File: doc/BRIEF.md
# SPI Serial Clock Baud Divider

This block turns the system clock into the serial clock for an SPI frame sequencer. The division ratio is the product of two factors. A 2-bit prescaler code picks a small odd-or-two factor. A 4-bit scaler code picks an even factor that grows linearly at first and then in powers of two. The block drives a level copy of the serial clock. It also drives single-cycle strobes on the cycle the clock goes high, on the cycle it goes low, and on either change. The sequencer uses these strobes to launch and capture bits.

The sequencer raises `run` for the length of a frame. While `run` is low, the divider sits idle with the serial clock low. In that state it keeps loading the codes presented to it. Once `run` goes high, the loaded ratio is frozen until the next idle period, so a frame always runs at one rate and starts from the same phase. The host software picks the codes for a wanted bit rate. The largest setting, 7 × 32768, serves as the fallback when nothing smaller is slow enough.

Top module: `spi_baud_div`

## Requirements
- R1: While reset is applied, and in the cycles after it, `sclk`, `tog_stb`, `rise_stb` and `fall_stb` are all 0.
- R2: While `run` is sampled low, `sclk` is 0 on the following cycle and no strobe is raised.
- R3: After `run` is first sampled high, `sclk` goes high on the L-th rising clock edge, counting that edge as the first. Here N is the ratio, H = floor(N/2) and L = N − H.
- R4: While `run` stays high, `sclk` stays high for H cycles and low for L cycles, so its period is N = prescaler factor × scaler factor system clocks.
- R5: Prescaler codes 0, 1, 2 and 3 select factors 2, 3, 5 and 7.
- R6: Scaler codes 0 to 3 select factors 2, 4, 6 and 8. A scaler code c from 4 to 15 selects the factor 2^c.
- R7: Changing the codes while `run` is high has no effect on the running clock. The new codes apply from the next frame, once `run` has been low for at least one cycle.
- R8: Dropping `run` in the middle of a high phase forces `sclk` low on the next cycle without a fall strobe. The next frame again starts with a full low phase of L cycles.
- R9: `rise_stb` is 1 exactly in the first cycle of each high phase and `fall_stb` exactly in the first cycle of each low phase that follows a high phase. The two strobes are never 1 together, and `tog_stb` is 1 whenever either one is.
- R10: With the largest setting (prescaler code 3, scaler code 15), the first low phase lasts 114688 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | High for the duration of a frame; low reloads codes and phase |
| pre_code | input | 2 | Prescaler code (factor 2, 3, 5, 7) |
| scl_code | input | 4 | Scaler code (factor 2, 4, 6, 8, then 2^code) |
| sclk | output | 1 | Divided serial clock level, idle low |
| tog_stb | output | 1 | One-cycle pulse on every serial clock change |
| rise_stb | output | 1 | One-cycle pulse in the first cycle of each high phase |
| fall_stb | output | 1 | One-cycle pulse in the first cycle of each low phase |

## Verification
The bench measures the first low phase, the high phase and the second low phase in system clocks for settings across both code tables. This catches a wrong factor, a half-period that is off by one, or a low/high split that is swapped. It changes the codes partway through a frame and expects the old rate to hold until the next frame. A design that reloads continuously would show the new period at once. It drops `run` during a high phase and expects an immediate low level with no fall strobe and a full low phase on restart. A counter that is not reloaded would instead resume partway through its count. The largest ratio is checked for a counter wide enough to reach 114688 without wrapping.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int PRE_W      = 2;
  localparam int SCL_W      = 4;
  localparam int PRE_FACT_W = 3;
  localparam int SCL_FACT_W = 1 << SCL_W;
  localparam int RATIO_W    = PRE_FACT_W + SCL_FACT_W;

  function automatic logic [PRE_FACT_W-1:0] pre_factor(input logic [PRE_W-1:0] code);
    logic [PRE_FACT_W-1:0] f;
    case (code)
      2'd0:    f = 3'd2;
      2'd1:    f = 3'd3;
      2'd2:    f = 3'd5;
      default: f = 3'd7;
    endcase
    return f;
  endfunction

  function automatic logic [SCL_FACT_W-1:0] scl_factor(input logic [SCL_W-1:0] code);
    logic [SCL_FACT_W-1:0] f;
    if (code < SCL_W'(4)) f = SCL_FACT_W'(({1'b0, code} + 5'd1) << 1);
    else                  f = SCL_FACT_W'(1) << code;
    return f;
  endfunction
endpackage

// File: rtl/baud_ratio.sv
module baud_ratio
  import baud_pkg::*;
(
  input  logic [PRE_W-1:0]   pre_code,
  input  logic [SCL_W-1:0]   scl_code,
  output logic [RATIO_W-1:0] lo_len,
  output logic [RATIO_W-1:0] hi_len
);
  logic [RATIO_W-1:0] ratio;

  always_comb begin
    ratio  = RATIO_W'(pre_factor(pre_code)) * RATIO_W'(scl_factor(scl_code));
    hi_len = ratio >> 1;
    lo_len = ratio - hi_len;
  end
endmodule

// File: rtl/baud_phase_cnt.sv
module baud_phase_cnt
  import baud_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RATIO_W-1:0] lo_len,
  input  logic [RATIO_W-1:0] hi_len,
  output logic               sclk,
  output logic               rise_stb,
  output logic               fall_stb
);
  logic [RATIO_W-1:0] lo_q, lo_d, hi_q, hi_d, cnt_q, cnt_d, cur_len;
  logic               phase_q, phase_d, rise_q, rise_d, fall_q, fall_d;
  logic               cfg_en, at_end;

  always_comb begin
    cfg_en  = ~run;
    cur_len = phase_q ? hi_q : lo_q;
    at_end  = (cnt_q == cur_len - RATIO_W'(1));
    lo_d    = cfg_en ? lo_len : lo_q;
    hi_d    = cfg_en ? hi_len : hi_q;
    cnt_d   = cnt_q + RATIO_W'(1);
    phase_d = phase_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    if (!run) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (at_end) begin
      cnt_d   = '0;
      phase_d = ~phase_q;
      rise_d  = ~phase_q;
      fall_d  = phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= RATIO_W'(2);
      hi_q    <= RATIO_W'(2);
      cnt_q   <= '0;
      phase_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign sclk     = phase_q;
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;
endmodule

// File: rtl/spi_baud_div.sv
module spi_baud_div
  import baud_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [SCL_W-1:0] scl_code,
  output logic             sclk,
  output logic             tog_stb,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   core_rst_n;
  logic [RATIO_W-1:0]     lo_len, hi_len;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_rst_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q[g] <= 1'b0;
        else if (g == 0) rst_sync_q[g] <= 1'b1;
        else rst_sync_q[g] <= rst_sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign core_rst_n = rst_sync_q[SYNC_STAGES-1];

  baud_ratio i_ratio (
    .pre_code (pre_code),
    .scl_code (scl_code),
    .lo_len   (lo_len),
    .hi_len   (hi_len)
  );

  baud_phase_cnt i_phase (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .run      (run),
    .lo_len   (lo_len),
    .hi_len   (hi_len),
    .sclk     (sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  assign tog_stb = rise_stb | fall_stb;
endmodule

// File: rtl/baud_div_chk.sv
module baud_div_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic sclk,
  input logic tog_stb,
  input logic rise_stb,
  input logic fall_stb
);
  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sclk && !rise_stb && !fall_stb));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb}));

  // R9
  rise_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> rise_stb);

  // R9
  rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> sclk);

  // R9
  fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!sclk && $past(sclk)));

  // R8
  fall_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && $past(run)) |-> fall_stb);

  // R9
  tog_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb || fall_stb) |-> tog_stb);
endmodule

bind spi_baud_div baud_div_chk i_baud_div_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .sclk     (sclk),
  .tog_stb  (tog_stb),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb)
);

// File: tb/test_spi_baud_div.sv
`timescale 1ns/1ps
module test_spi_baud_div;
  logic       clk;
  logic       rst_n;
  logic       run;
  logic [1:0] pre_code;
  logic [3:0] scl_code;
  logic       sclk, tog_stb, rise_stb, fall_stb;
  int         n_checks;
  int         n_fail;

  spi_baud_div i_spi_baud_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .pre_code (pre_code),
    .scl_code (scl_code),
    .sclk     (sclk),
    .tog_stb  (tog_stb),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int pre_f(input int c);
    case (c)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int scl_f(input int c);
    if (c < 4) return 2 * (c + 1);
    return 1 << c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count negedges until sclk equals lvl; returns count
  task automatic count_until(input logic lvl, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sclk != lvl && n < limit);
  endtask

  task automatic idle(input int p, input int s);
    @(negedge clk);
    run = 1'b0;
    pre_code = 2'(p);
    scl_code = 4'(s);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; run = 1'b0; pre_code = '0; scl_code = '0;
    repeat (3) @(negedge clk);
    check("R1 sclk in reset", int'(sclk), 0);
    check("R1 strobes in reset", int'({tog_stb, rise_stb, fall_stb}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 sclk after reset", int'(sclk), 0);
    check("R1 strobes after reset", int'({tog_stb, rise_stb, fall_stb}), 0);
  endtask

  task automatic t_ratio(input int p, input int s, input string tag);
    int n, nn, hh, ll;
    nn = pre_f(p) * scl_f(s);
    hh = nn / 2;
    ll = nn - hh;
    idle(p, s);
    check({tag, " R2 idle low"}, int'(sclk), 0);
    run = 1'b1;
    count_until(1'b1, nn + 4, n);
    check({tag, " R3 first low phase"}, n, ll);
    check({tag, " R9 rise strobe"}, int'({rise_stb, fall_stb, tog_stb}), 3'b101);
    count_until(1'b0, nn + 4, n);
    check({tag, " R4 high phase"}, n, hh);
    check({tag, " R9 fall strobe"}, int'({rise_stb, fall_stb, tog_stb}), 3'b011);
    count_until(1'b1, nn + 4, n);
    check({tag, " R4 second low phase"}, n, ll);
    @(negedge clk);
    check({tag, " R9 strobe one cycle"}, int'(tog_stb), 0);
    run = 1'b0;
    @(negedge clk);
    check({tag, " R2 run low forces sclk low"}, int'({sclk, tog_stb}), 0);
  endtask

  task automatic t_code_change;
    int n;
    idle(0, 1); // ratio 8
    run = 1'b1;
    count_until(1'b1, 40, n);
    pre_code = 2'd3; scl_code = 4'd3; // ratio 56, must not apply yet
    count_until(1'b0, 40, n);
    check("R7 high phase keeps old ratio", n, 4);
    count_until(1'b1, 80, n);
    check("R7 low phase keeps old ratio", n, 4);
    // drop run mid high phase
    repeat (2) @(negedge clk);
    check("R8 still high before drop", int'(sclk), 1);
    run = 1'b0;
    @(negedge clk);
    check("R8 sclk low after drop", int'(sclk), 0);
    check("R8 no fall strobe on drop", int'({fall_stb, tog_stb}), 0);
    @(negedge clk);
    run = 1'b1;
    count_until(1'b1, 100, n);
    check("R7 new ratio after idle", n, 28);
    check("R8 full low phase on restart", int'(rise_stb), 1);
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_max;
    int n;
    idle(3, 15);
    run = 1'b1;
    count_until(1'b1, 120000, n);
    check("R10 max ratio low phase", n, 114688);
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    t_reset();
    t_ratio(0, 0, "R5 R6 p0s0");
    t_ratio(1, 0, "R5 p1s0");
    t_ratio(2, 1, "R5 p2s1");
    t_ratio(3, 3, "R5 R6 p3s3");
    t_ratio(2, 2, "R6 p2s2");
    t_ratio(1, 4, "R6 p1s4");
    t_ratio(0, 7, "R6 p0s7");
    t_ratio(0, 10, "R6 p0s10");
    t_code_change();
    t_max();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule